// File: doc/BRIEF.md
# Dual-Channel ADC Read Sequencer

This block is host-side glue for a two-channel parallel converter that samples both channels at once. A conversion starts from a one-cycle internal request or from an external start input; either one reaches the converter's start line. The block then watches the converter's busy line. When busy has been seen high and has dropped again, both channels are finished. The sequencer then runs two read cycles, one after the other, at one decoded address. The converter returns one channel on the first read and the other channel on the second.

Each read cycle is built the way a processor bus builds one. A strobe and a read/write qualifier are combined with an address-decode chip select to form the active-low read strobe. A wait-state counter then holds that strobe for one extra cycle. The 14-bit results are taken from the low bits of the data bus on the last cycle of each strobe. A sticky valid flag is set after the second read, and an interrupt pulse goes out at the same time. The flag stays set until the host acknowledges it.

Top module: `adc_pair_reader`

## Requirements
- R1: In idle, a high `start_req_i` sampled on a clock edge drives `conv_start_o` high for exactly START_LEN (default 2) cycles starting at that edge. In idle, `ext_start_i` appears on `conv_start_o` in the same cycle, with no register delay.
- R2: A start request on either input is ignored outside idle. `conv_start_o` stays low and no extra read cycles follow.
- R3: Reads begin only after the synchronised busy line has been seen high and then low. While busy has not yet risen, no read strobe occurs.
- R4: Each conversion produces exactly two read strobes. Both are issued at the same decoded address, so `cs_n_o` is low for each of them.
- R5: Each read strobe stays low for exactly 1 + WAIT_STATES cycles (default 2). Two strobes are separated by at least one cycle with the strobe high.
- R6: The first read is captured into `res_a_o` and the second into `res_b_o`. Each result is taken from bus bits 13..0, and the upper bus bits are dropped.
- R7: `res_valid_o` rises after the second read and stays high until `host_ack_i` clears it. `irq_o` pulses for exactly one cycle per completed pair.
- R8: After reset, `conv_start_o` is 0, `rd_n_o` and `cs_n_o` are 1, both results are 0, and `res_valid_o` and `irq_o` are 0.
- R9: `rd_n_o` is never low while `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Internal conversion request |
| ext_start_i | input | 1 | External conversion start |
| busy_i | input | 1 | Converter busy, high while converting |
| adc_data_i | input | 16 | Converter data bus |
| host_ack_i | input | 1 | Host acknowledge, clears the valid flag |
| conv_start_o | output | 1 | Start line to the converter |
| cs_n_o | output | 1 | Active-low chip select from address decode |
| rd_n_o | output | 1 | Active-low read strobe, stretched by the wait state |
| res_a_o | output | 14 | First-read result |
| res_b_o | output | 14 | Second-read result |
| res_valid_o | output | 1 | Sticky result-valid flag |
| irq_o | output | 1 | One-cycle interrupt when both results are captured |

## Verification
The case hardest to reach from the ports is a start request arriving in the middle of a conversion. The bench reaches it by holding busy low after a start, which keeps the sequencer parked in its wait state. While it is parked, the bench pulses both start inputs and confirms that the start line stays quiet and that no reads appear. A bus-side model counts strobe widths and read order. It also returns a different word on each read, with junk in the upper bits, so that swapped channels or unmasked bits show up in the results.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WAIT_BUSY, ST_READ_A, ST_READ_B, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic strb;
    logic rd;
  } bus_req_t;
endpackage

// File: rtl/busy_sync.sv
module busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic busy_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], busy_i};
  end

  assign busy_o = sr_q[STAGES-1];
endmodule

// File: rtl/rd_strobe_gen.sv
module rd_strobe_gen
  import adc_pair_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADC_ADDR  = 8'h5C,
  parameter int              WAIT_STATES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_req_t          req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              rdy_o
);
  localparam int CW = $clog2(WAIT_STATES + 1) + 1;

  logic          sel;
  logic          rd_act;
  logic [CW-1:0] ws_q;

  assign sel    = (addr_i == ADC_ADDR);
  assign rd_act = req_i.strb & req_i.rd & sel;
  assign cs_n_o = ~sel;
  assign rd_n_o = ~rd_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ws_q <= '0;
    else if (!rd_act)                       ws_q <= '0;
    else if (ws_q != CW'(WAIT_STATES))      ws_q <= ws_q + 1'b1;
  end

  // ready on the final stretched cycle
  assign rdy_o = rd_act & (ws_q == CW'(WAIT_STATES));

  assert_rdy_after_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> $past(rd_act));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import adc_pair_pkg::*;
#(
  parameter int                START_LEN = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADC_ADDR  = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              ext_start_i,
  input  logic              busy_s_i,
  input  logic              rdy_i,
  output logic              conv_start_o,
  output bus_req_t          req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cap_a_o,
  output logic              cap_b_o
);
  localparam int SW = $clog2(START_LEN + 1) + 1;

  seq_state_e    st_q;
  logic [SW-1:0] scnt_q;
  logic          seen_q;
  logic          strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      scnt_q <= '0;
      seen_q <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          scnt_q <= '0;
          seen_q <= 1'b0;
          if (start_req_i)      st_q <= ST_START;
          else if (ext_start_i) st_q <= ST_WAIT_BUSY;
        end
        ST_START: begin
          if (scnt_q == SW'(START_LEN - 1)) st_q <= ST_WAIT_BUSY;
          else                              scnt_q <= scnt_q + 1'b1;
        end
        ST_WAIT_BUSY: begin
          if (busy_s_i) seen_q <= 1'b1;
          else if (seen_q) begin
            st_q   <= ST_READ_A;
            strb_q <= 1'b1;
          end
        end
        ST_READ_A: begin
          if (strb_q && rdy_i) strb_q <= 1'b0;
          else if (!strb_q) begin
            st_q   <= ST_READ_B;
            strb_q <= 1'b1;
          end
        end
        ST_READ_B: begin
          if (strb_q && rdy_i) strb_q <= 1'b0;
          else if (!strb_q)    st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_start_o = (st_q == ST_START) | (ext_start_i & (st_q == ST_IDLE));
  assign req_o.strb   = strb_q;
  assign req_o.rd     = 1'b1;
  assign addr_o       = strb_q ? ADC_ADDR : ~ADC_ADDR;
  assign cap_a_o      = (st_q == ST_READ_A) & strb_q & rdy_i;
  assign cap_b_o      = (st_q == ST_READ_B) & strb_q & rdy_i;

  assert_start_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_START) |-> $past(st_q == ST_IDLE));
  assert_read_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_READ_A) |-> $past(seen_q && !busy_s_i));
  assert_b_follows_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ_B) |-> $past(st_q == ST_READ_A || st_q == ST_READ_B));
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int BUS_W = 16,
  parameter int RES_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_a_i,
  input  logic             cap_b_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic             ack_i,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             valid_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_o <= '0;
      res_b_o <= '0;
      valid_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (cap_a_i) res_a_o <= data_i[RES_W-1:0];
      if (cap_b_i) res_b_o <= data_i[RES_W-1:0];
      irq_o <= cap_b_i;
      if (cap_b_i)    valid_o <= 1'b1;
      else if (ack_i) valid_o <= 1'b0;
    end
  end

  assert_valid_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> valid_o);
  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/adc_pair_reader.sv
module adc_pair_reader
  import adc_pair_pkg::*;
#(
  parameter int                BUS_W       = 16,
  parameter int                RES_W       = 14,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADC_ADDR    = 8'h5C,
  parameter int                START_LEN   = 2,
  parameter int                WAIT_STATES = 1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  input  logic             ext_start_i,
  input  logic             busy_i,
  input  logic [BUS_W-1:0] adc_data_i,
  input  logic             host_ack_i,
  output logic             conv_start_o,
  output logic             cs_n_o,
  output logic             rd_n_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             res_valid_o,
  output logic             irq_o
);
  logic              busy_s;
  logic              rdy;
  logic              cap_a, cap_b;
  bus_req_t          req;
  logic [ADDR_W-1:0] addr;

  busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .busy_i, .busy_o(busy_s)
  );

  seq_fsm #(.START_LEN(START_LEN), .ADDR_W(ADDR_W), .ADC_ADDR(ADC_ADDR)) u_seq (
    .clk_i, .rst_ni, .start_req_i, .ext_start_i, .busy_s_i(busy_s), .rdy_i(rdy),
    .conv_start_o, .req_o(req), .addr_o(addr), .cap_a_o(cap_a), .cap_b_o(cap_b)
  );

  rd_strobe_gen #(.ADDR_W(ADDR_W), .ADC_ADDR(ADC_ADDR), .WAIT_STATES(WAIT_STATES)) u_strb (
    .clk_i, .rst_ni, .req_i(req), .addr_i(addr), .cs_n_o, .rd_n_o, .rdy_o(rdy)
  );

  result_bank #(.BUS_W(BUS_W), .RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .cap_a_i(cap_a), .cap_b_i(cap_b), .data_i(adc_data_i),
    .ack_i(host_ack_i), .res_a_o, .res_b_o, .valid_o(res_valid_o), .irq_o
  );

  assert_rd_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !cs_n_o);
  assert_irq_sets_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> res_valid_o);
endmodule

// File: tb/adc_pair_reader_test.sv
`timescale 1ns/1ps
module adc_pair_reader_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_req = 1'b0, ext_start = 1'b0, busy = 1'b0, ack = 1'b0;
  logic [15:0] data;
  logic        conv_start, cs_n, rd_n, res_valid, irq;
  logic [13:0] res_a, res_b;
  logic [13:0] cur_a = '0, cur_b = '0;

  int total = 0, bad = 0;
  int pulses = 0, low_len = 0, width_bad = 0, gap_bad = 0, cs_viol = 0;
  int irq_cnt = 0, conv_cnt = 0, high_len = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign data = {2'b11, (pulses % 2 == 0) ? cur_a : cur_b};

  adc_pair_reader uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_req_i(start_req), .ext_start_i(ext_start),
    .busy_i(busy), .adc_data_i(data), .host_ack_i(ack), .conv_start_o(conv_start),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .res_a_o(res_a), .res_b_o(res_b),
    .res_valid_o(res_valid), .irq_o(irq)
  );

  always @(negedge clk) if (rst_ni) begin
    if (!rd_n) begin
      if (low_len == 0 && pulses > 0 && high_len < 1) gap_bad++;
      low_len++;
      high_len = 0;
      if (cs_n) cs_viol++;
    end else begin
      if (low_len != 0) begin
        if (low_len != 2) width_bad++;
        pulses++;
        low_len = 0;
      end
      high_len++;
    end
    if (irq) irq_cnt++;
    if (conv_start) conv_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    pulses = 0; width_bad = 0; gap_bad = 0; cs_viol = 0; irq_cnt = 0; conv_cnt = 0;
  endtask

  task automatic busy_pulse();
    @(posedge clk); #1 busy = 1'b1;
    repeat (8) @(posedge clk);
    #1 busy = 1'b0;
  endtask

  task automatic finish_pair(input logic [13:0] a, input logic [13:0] b, input string tag);
    int n = 0;
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(pulses == 2, "R4 read count", pulses, 2);
    check(width_bad == 0, "R5 strobe width", width_bad, 0);
    check(gap_bad == 0, "R5 strobe gap", gap_bad, 0);
    check(cs_viol == 0, "R9 rd without cs", cs_viol, 0);
    check(res_a == a, {"R6 res_a ", tag}, res_a, a);
    check(res_b == b, {"R6 res_b ", tag}, res_b, b);
    check(irq_cnt == 1, "R7 irq pulses", irq_cnt, 1);
    check(res_valid == 1'b1, "R7 valid sticky", res_valid, 1);
    @(posedge clk); #1 ack = 1'b1;
    @(posedge clk); #1 ack = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R7 valid cleared by ack", res_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(conv_start == 0, "R8 conv_start", conv_start, 0);
    check(rd_n == 1 && cs_n == 1, "R8 strobes idle", {rd_n, cs_n}, 3);
    check(res_a == 0 && res_b == 0, "R8 results", res_a | res_b, 0);
    check(res_valid == 0 && irq == 0, "R8 flags", {res_valid, irq}, 0);
  endtask

  task automatic t_int_start();
    cur_a = 14'h1234; cur_b = 14'h2ABC;
    clr_mon();
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
    repeat (4) @(negedge clk);
    check(conv_cnt == 2, "R1 internal start length", conv_cnt, 2);
    busy_pulse();
    finish_pair(14'h1234, 14'h2ABC, "internal");
  endtask

  task automatic t_ext_start();
    cur_a = 14'h3FFF; cur_b = 14'h0001;
    clr_mon();
    @(posedge clk); #1 ext_start = 1'b1;
    @(negedge clk);
    check(conv_start == 1, "R1 external start passthrough", conv_start, 1);
    @(posedge clk); #1 ext_start = 1'b0;
    busy_pulse();
    finish_pair(14'h3FFF, 14'h0001, "external");
  endtask

  task automatic t_ignored();
    cur_a = 14'h0F0F; cur_b = 14'h30C3;
    clr_mon();
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(pulses == 0, "R3 no read before busy", pulses, 0);
    @(posedge clk); #1 start_req = 1'b1; ext_start = 1'b1;
    @(negedge clk);
    check(conv_start == 0, "R2 start ignored while waiting", conv_start, 0);
    @(posedge clk); #1 start_req = 1'b0; ext_start = 1'b0;
    @(posedge clk); #1 busy = 1'b1;
    repeat (3) @(posedge clk);
    #1 ext_start = 1'b1;
    @(negedge clk);
    check(conv_start == 0, "R2 start ignored while busy", conv_start, 0);
    @(posedge clk); #1 ext_start = 1'b0;
    repeat (4) @(posedge clk);
    #1 busy = 1'b0;
    finish_pair(14'h0F0F, 14'h30C3, "ignored");
    check(conv_cnt == 2, "R2 no extra start pulses", conv_cnt, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_int_start();
    t_ext_start();
    t_ignored();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule